// File: doc/BRIEF.md
# Low-Side Overcurrent Trip Manager

This block sits in the digital control of a synchronous buck converter. It works on the cycle boundaries and does not measure current. A one-clock pulse marks the start of each switching period, a level says that the low-side switch is conducting, and a comparator flag says that the low-side current is above the trip level. The flag is ignored for a programmable number of clocks after the low-side switch turns on, so that switching ringing cannot cause a trip. A trip that passes this window is counted, and the high-side pulses that follow it are suppressed.

A tally keeps the number of trips that come close together. At most one trip counts in any switching period. After a trip, the high-side switch stays off until a period starts while the comparator is low. A run of clean periods forgives earlier trips and returns the tally to zero. A trip that takes the tally to its limit produces a one-clock hiccup request, which the power sequencer uses to shut the stage down and restart it. The block has no soft-start input, so its detection works the same during a normal start-up and during the restart that follows a hiccup.

Top module: `ocp_trip_mgr`

## Requirements
- R1: After reset, and on the clock edge after `enable` goes low, `trip_count` is 0 and `hs_skip` and `hiccup_req` are 0. While `enable` is low, no trip is counted.
- R2: `oc_over` is ignored during the first BLANK_CYC clocks in which `ls_on` is high (default 15, which is 150 ns at 100 MHz).
- R3: If `oc_over` and `ls_on` are both high at the clock edge that follows those BLANK_CYC clocks, the same edge raises `trip_count` by one and sets `hs_skip` to 1.
- R4: `oc_over` has no effect while `ls_on` is low.
- R5: Only one trip counts in a switching period, however long `oc_over` stays high. A period runs from one `cycle_tick` pulse to the next.
- R6: `hs_skip` clears on a `cycle_tick` edge at which `oc_over` is low. If `oc_over` is high at that tick, `hs_skip` stays at 1.
- R7: When `trip_count` is not zero, `trip_count` returns to 0 on the tick that ends the seventh switching period in a row without a trip (CLEAN_LIMIT, default 7). A tick that ends a period in which a trip occurred is not clean.
- R8: A trip restarts the count of clean periods. Six clean periods, then a trip, leave `trip_count` at 2.
- R9: The trip that would take the tally to TRIP_LIMIT (default 3) pulses `hiccup_req` for exactly one clock. On that edge, `trip_count` and `hs_skip` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block active; low clears all state |
| cycle_tick | input | 1 | One-clock pulse at the start of each switching period |
| ls_on | input | 1 | Low-side switch is conducting |
| oc_over | input | 1 | Comparator: low-side current above the trip level |
| hs_skip | output | 1 | High-side pulse suppressed |
| trip_count | output | $clog2(TRIP_LIMIT+1) | Consecutive trips counted so far |
| hiccup_req | output | 1 | One-clock request to enter hiccup |

## Verification
All outputs are registered, so every result appears on the first clock edge that samples the stimulus. The one exception is a trip, which can appear only after BLANK_CYC clocks with `ls_on` high: in the bench, `trip_count` is still 0 after 15 edges and reaches 1 on the 16th. The bench changes inputs on falling edges and reads outputs on the falling edge after the edge under test. Each tick is one clock wide, so a clean-period count is checked right after the sixth tick and again right after the seventh.

// File: rtl/ocp_trip_pkg.sv
package ocp_trip_pkg;
   // width needed to hold values 0..n
   function automatic int cnt_w(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/ocp_blank_gate.sv
module ocp_blank_gate
   import ocp_trip_pkg::*;
#(
   parameter int BLANK_CYC = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ls_on,
   input  logic oc_over,
   output logic qual
);
   if (BLANK_CYC < 0) begin : g_bad_blank
      $error("BLANK_CYC must not be negative");
   end

   if (BLANK_CYC == 0) begin : g_no_blank
      assign qual = ls_on & oc_over & ~clr;
   end else begin : g_blank
      localparam int BW = cnt_w(BLANK_CYC);
      localparam logic [BW-1:0] BMAX = BW'(BLANK_CYC);
      logic [BW-1:0] bcnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  bcnt <= '0;
         else if (clr || !ls_on)      bcnt <= '0;
         else if (bcnt != BMAX)       bcnt <= bcnt + 1'b1;
      end

      assign qual = ls_on & oc_over & ~clr & (bcnt == BMAX);

      // R2
      qual_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
         qual |-> $past(ls_on));
   end
endmodule

// File: rtl/ocp_cycle_track.sv
module ocp_cycle_track (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cycle_tick,
   input  logic qual,
   input  logic oc_over,
   input  logic fire,
   output logic trip_evt,
   output logic cycle_hit,
   output logic skip
);
   assign trip_evt = qual & ~cycle_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cycle_hit <= 1'b0;
      else if (clr)        cycle_hit <= 1'b0;
      else if (cycle_tick) cycle_hit <= 1'b0;
      else if (trip_evt)   cycle_hit <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      skip <= 1'b0;
      else if (clr || fire)            skip <= 1'b0;
      else if (trip_evt)               skip <= 1'b1;
      else if (cycle_tick && !oc_over) skip <= 1'b0;
   end

   // R6
   skip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(skip) |-> ($past(cycle_tick) && !$past(oc_over)) || $past(clr) || $past(fire));

   // R5
   one_trip_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_hit && !cycle_tick && !clr) |=> !trip_evt);
endmodule

// File: rtl/ocp_trip_tally.sv
module ocp_trip_tally
   import ocp_trip_pkg::*;
#(
   parameter int TRIP_LIMIT  = 3,
   parameter int CLEAN_LIMIT = 7,
   parameter int TW          = cnt_w(TRIP_LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          cycle_tick,
   input  logic          trip_evt,
   input  logic          cycle_hit,
   output logic [TW-1:0] trip_count,
   output logic          fire,
   output logic          hiccup_req
);
   if (TRIP_LIMIT < 1) begin : g_bad_trip
      $error("TRIP_LIMIT must be at least 1");
   end
   if (CLEAN_LIMIT < 1) begin : g_bad_clean
      $error("CLEAN_LIMIT must be at least 1");
   end

   localparam int CW = cnt_w(CLEAN_LIMIT);
   localparam logic [TW-1:0] LAST_T = TW'(TRIP_LIMIT - 1);
   localparam logic [CW-1:0] LAST_C = CW'(CLEAN_LIMIT - 1);

   logic [CW-1:0] clean_cnt;

   assign fire = trip_evt & (trip_count == LAST_T);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip_count <= '0;
         clean_cnt  <= '0;
         hiccup_req <= 1'b0;
      end else if (clr) begin
         trip_count <= '0;
         clean_cnt  <= '0;
         hiccup_req <= 1'b0;
      end else begin
         hiccup_req <= fire;
         if (fire) begin
            trip_count <= '0;
            clean_cnt  <= '0;
         end else if (trip_evt) begin
            trip_count <= trip_count + 1'b1;
            clean_cnt  <= '0;
         end else if (cycle_tick && !cycle_hit && trip_count != '0) begin
            if (clean_cnt == LAST_C) begin
               trip_count <= '0;
               clean_cnt  <= '0;
            end else begin
               clean_cnt <= clean_cnt + 1'b1;
            end
         end
      end
   end

   // R9
   hiccup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hiccup_req |=> !hiccup_req);

   // R9
   hiccup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hiccup_req |-> trip_count == '0);

   // R7
   count_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_count < $past(trip_count)) |-> $past(cycle_tick) || $past(clr) || $past(fire));

   // R3
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_count <= LAST_T);
endmodule

// File: rtl/ocp_trip_mgr.sv
module ocp_trip_mgr
   import ocp_trip_pkg::*;
#(
   parameter int BLANK_CYC   = 15,
   parameter int TRIP_LIMIT  = 3,
   parameter int CLEAN_LIMIT = 7,
   localparam int TW         = cnt_w(TRIP_LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          cycle_tick,
   input  logic          ls_on,
   input  logic          oc_over,
   output logic          hs_skip,
   output logic [TW-1:0] trip_count,
   output logic          hiccup_req
);
   logic clr, qual, trip_evt, cycle_hit, fire;

   assign clr = ~enable;

   ocp_blank_gate #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk(clk), .rst_n(rst_n), .clr(clr), .ls_on(ls_on),
      .oc_over(oc_over), .qual(qual));

   ocp_cycle_track u_track (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cycle_tick(cycle_tick),
      .qual(qual), .oc_over(oc_over), .fire(fire),
      .trip_evt(trip_evt), .cycle_hit(cycle_hit), .skip(hs_skip));

   ocp_trip_tally #(.TRIP_LIMIT(TRIP_LIMIT), .CLEAN_LIMIT(CLEAN_LIMIT), .TW(TW)) u_tally (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cycle_tick(cycle_tick),
      .trip_evt(trip_evt), .cycle_hit(cycle_hit),
      .trip_count(trip_count), .fire(fire), .hiccup_req(hiccup_req));

   // R1
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (trip_count == '0) && !hs_skip && !hiccup_req);

   // R4
   ls_off_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ls_on && !hiccup_req) |=> trip_count <= $past(trip_count) || $past(cycle_tick) == 1'b0 && 1'b0);
endmodule

// File: tb/ocp_trip_mgr_tb.sv
module ocp_trip_mgr_tb;
   localparam int BLANK = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, cycle_tick = 1'b0, ls_on = 1'b0, oc_over = 1'b0;
   logic hs_skip, hiccup_req;
   logic [1:0] trip_count;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   ocp_trip_mgr u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cycle_tick(cycle_tick),
      .ls_on(ls_on), .oc_over(oc_over), .hs_skip(hs_skip),
      .trip_count(trip_count), .hiccup_req(hiccup_req));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick();
      cycle_tick = 1'b1;
      clocks(1);
      cycle_tick = 1'b0;
   endtask

   // low side on with overcurrent for blank+1 edges, then release
   task automatic trip_once();
      ls_on = 1'b1; oc_over = 1'b1;
      clocks(BLANK + 1);
      ls_on = 1'b0; oc_over = 1'b0;
   endtask

   task automatic restart();
      enable = 1'b0; ls_on = 1'b0; oc_over = 1'b0; cycle_tick = 1'b0;
      clocks(2);
      enable = 1'b1;
      clocks(1);
   endtask

   task automatic t_reset();
      check("R1", "count after reset", trip_count, 0);
      check("R1", "skip after reset", hs_skip, 0);
      check("R1", "hiccup after reset", hiccup_req, 0);
   endtask

   task automatic t_blank();
      restart();
      ls_on = 1'b1; oc_over = 1'b1;
      clocks(BLANK);
      check("R2", "count inside blanking", trip_count, 0);
      check("R2", "skip inside blanking", hs_skip, 0);
      clocks(1);
      check("R3", "count after blanking", trip_count, 1);
      check("R3", "skip after trip", hs_skip, 1);
      ls_on = 1'b0; oc_over = 1'b0;
      // R2: overcurrent only during a short low-side window is ignored
      tick();
      ls_on = 1'b1; clocks(3); oc_over = 1'b1; clocks(BLANK - 4);
      ls_on = 1'b0; oc_over = 1'b0; clocks(1);
      check("R2", "short window ignored", trip_count, 1);
   endtask

   task automatic t_ls_off();
      restart();
      oc_over = 1'b1;
      clocks(40);
      check("R4", "count with ls off", trip_count, 0);
      check("R4", "skip with ls off", hs_skip, 0);
      oc_over = 1'b0;
   endtask

   task automatic t_one_per_cycle();
      restart();
      ls_on = 1'b1; oc_over = 1'b1;
      clocks(BLANK + 40);
      check("R5", "count with long overcurrent", trip_count, 1);
      ls_on = 1'b0; oc_over = 1'b0;
      tick();
      ls_on = 1'b1; oc_over = 1'b1;
      clocks(BLANK + 1);
      check("R5", "next cycle counts again", trip_count, 2);
      ls_on = 1'b0; oc_over = 1'b0;
   endtask

   task automatic t_skip();
      restart();
      trip_once();
      oc_over = 1'b1;
      tick();
      check("R6", "skip held with comparator high", hs_skip, 1);
      oc_over = 1'b0;
      clocks(3);
      check("R6", "skip held mid cycle", hs_skip, 1);
      tick();
      check("R6", "skip released on tick", hs_skip, 0);
   endtask

   task automatic t_backup();
      restart();
      trip_once();
      tick();
      for (int i = 0; i < 6; i++) begin tick(); clocks(2); end
      check("R7", "count after six clean", trip_count, 1);
      tick();
      check("R7", "count after seven clean", trip_count, 0);
      trip_once();
      tick();
      for (int i = 0; i < 6; i++) begin tick(); clocks(2); end
      trip_once();
      check("R8", "six clean then trip", trip_count, 2);
      tick();
      for (int i = 0; i < 6; i++) tick();
      check("R8", "restarted backup holds", trip_count, 2);
      tick();
      check("R8", "restarted backup clears", trip_count, 0);
   endtask

   task automatic t_hiccup();
      restart();
      trip_once(); tick();
      trip_once(); tick();
      check("R9", "count before third", trip_count, 2);
      check("R9", "no hiccup yet", hiccup_req, 0);
      ls_on = 1'b1; oc_over = 1'b1;
      clocks(BLANK + 1);
      check("R9", "hiccup raised", hiccup_req, 1);
      check("R9", "count cleared on hiccup", trip_count, 0);
      check("R9", "skip cleared on hiccup", hs_skip, 0);
      ls_on = 1'b0; oc_over = 1'b0;
      clocks(1);
      check("R9", "hiccup one clock", hiccup_req, 0);
   endtask

   task automatic t_disable();
      restart();
      trip_once(); tick();
      trip_once();
      check("R1", "count before disable", trip_count, 2);
      enable = 1'b0;
      clocks(1);
      check("R1", "count cleared by disable", trip_count, 0);
      check("R1", "skip cleared by disable", hs_skip, 0);
      ls_on = 1'b1; oc_over = 1'b1;
      clocks(BLANK + 5);
      check("R1", "no trip while disabled", trip_count, 0);
      ls_on = 1'b0; oc_over = 1'b0;
      enable = 1'b1;
      clocks(1);
   endtask

   initial begin
      clocks(3);
      rst_n = 1'b1;
      clocks(1);
      t_reset();
      enable = 1'b1;
      t_blank();
      t_ls_off();
      t_one_per_cycle();
      t_skip();
      t_backup();
      t_hiccup();
      t_disable();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #100000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule